// File: doc/BRIEF.md
# Packed SIMD Multiply Low/High Unit

This block multiplies two 128-bit packed integer vectors lane by lane. Each lane of the result holds either the lower half or the upper half of the double-width product of the matching source lanes. Lanes can be 8, 16, 32 or 64 bits wide, which gives 16, 8, 4 or 2 lanes. The upper-half forms come in a signed version and an unsigned version. Because the upper half is offered at 64-bit lane width, each 64-bit lane pair needs a full 128-bit product.

The unit decodes a 32-bit instruction word itself. It checks the major opcode, maps the 5-bit minor code onto lane size, half and signedness, and splits out three 5-bit vector register numbers. The two source register numbers come out combinationally so that a register file can be read in the same cycle. The destination number travels with the result. Any instruction that does not decode is flagged as illegal, and its result is forced to zero.

By default the result sits behind one register stage. A parameter can select a purely combinational path instead.

Top module: `simd_mul_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid`, `illegal_op`, `result` and `dst_idx` are all zero.
- R2: With the default registered variant, `out_valid` equals `in_valid` delayed by one clock cycle.
- R3: Minor codes 01000 to 01011 select the low multiply, with the lane size taken from minor bits [1:0] (00 = 8, 01 = 16, 10 = 32, 11 = 64 bits). Each lane of the result holds the lower lane-width bits of the lane product. This value is the same whether the operands are read as signed or as unsigned.
- R4: Minor codes 01100 to 01111 select the signed high multiply. Each lane holds bits [2N-1:N] of the 2N-bit two's-complement product of the N-bit lanes.
- R5: Minor codes 10000 to 10011 select the unsigned high multiply. Each lane holds bits [2N-1:N] of the unsigned 2N-bit product.
- R6: For 64-bit lanes, the high multiply returns the upper 64 bits of the exact 128-bit product of each of the two lane pairs. This includes most-negative × most-negative = 0x4000_0000_0000_0000 when signed.
- R7: No lane affects another lane. Products that fill the full 2N bits stay inside their own lane.
- R8: The instruction is legal only when bits [31:28] are 0111, bits [27:20] are 00001000, and the minor code in bits [19:15] is one of those listed in R3 to R5. For any other accepted word, `illegal_op` is 1 together with `out_valid`, and `result` is zero.
- R9: `rd_idx_a` equals instruction bits [9:5] and `rd_idx_b` equals bits [14:10], combinationally. `dst_idx` returns bits [4:0] of the accepted word, together with its result.
- R10: On a cycle with `in_valid` low, nothing is accepted. On the next cycle `out_valid` and `illegal_op` are 0, and `result` and `dst_idx` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction and its operands are presented |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| rd_idx_a | output | 5 | First source register number, combinational |
| rd_idx_b | output | 5 | Second source register number, combinational |
| out_valid | output | 1 | Result is present |
| illegal_op | output | 1 | Accepted instruction did not decode |
| result | output | 128 | Packed lane results |
| dst_idx | output | 5 | Destination register number for `result` |

## Verification
The bound checker watches the handshake and flag rules on every cycle. These are: the one-cycle valid delay, a zero result whenever the illegal flag is set, the illegal flag never appearing without a valid result, the destination number following the accepted word, and the result holding on idle cycles.

The arithmetic can only be shown by the bench. It compares every lane of every opcode and lane size against a wide reference product. Directed cases cover most-negative squared, −1 squared and all-ones squared at each lane width, alongside random operands. The bench also covers lane isolation and the decoding of bad words.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

   // Lane size code carried in the low two bits of the minor field
   typedef enum logic [1:0] {
      LSZ_8  = 2'b00,
      LSZ_16 = 2'b01,
      LSZ_32 = 2'b10,
      LSZ_64 = 2'b11
   } lane_sz_e;

   // Decoded operation
   typedef struct packed {
      lane_sz_e size;
      logic     high;   // 1: upper half of the product
      logic     sgn;    // 1: operands read as two's complement
      logic     legal;
   } mul_op_t;

   localparam int NUM_SIZES  = 4;
   localparam int MIN_LANE_W = 8;
   localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);

   localparam logic [3:0] MAJOR_CODE = 4'b0111;
   localparam logic [7:0] GROUP_CODE = 8'b00001000;

   // Minor field bits [4:2] select the kind
   localparam logic [2:0] KIND_LOW  = 3'b010;
   localparam logic [2:0] KIND_HI_S = 3'b011;
   localparam logic [2:0] KIND_HI_U = 3'b100;

   localparam int REG_IDX_W = 5;

endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
   import simd_mul_pkg::*;
(
   input  logic [31:0]          insn,
   output mul_op_t              op,
   output logic [REG_IDX_W-1:0] dst,
   output logic [REG_IDX_W-1:0] srca,
   output logic [REG_IDX_W-1:0] srcb
);

   logic [3:0] major;
   logic [7:0] group;
   logic [4:0] minor;
   logic       prefix_ok;

   assign major = insn[31:28];
   assign group = insn[27:20];
   assign minor = insn[19:15];
   assign prefix_ok = (major == MAJOR_CODE) && (group == GROUP_CODE);

   assign dst  = insn[REG_IDX_W-1:0];
   assign srca = insn[2*REG_IDX_W-1:REG_IDX_W];
   assign srcb = insn[3*REG_IDX_W-1:2*REG_IDX_W];

   always_comb begin
      op       = '0;
      op.size  = lane_sz_e'(minor[1:0]);
      if (prefix_ok) begin
         unique case (minor[4:2])
            KIND_LOW: begin
               op.legal = 1'b1;
               op.high  = 1'b0;
               op.sgn   = 1'b0;
            end
            KIND_HI_S: begin
               op.legal = 1'b1;
               op.high  = 1'b1;
               op.sgn   = 1'b1;
            end
            KIND_HI_U: begin
               op.legal = 1'b1;
               op.high  = 1'b1;
               op.sgn   = 1'b0;
            end
            default: op.legal = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/simd_mul_lane.sv
module simd_mul_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sgn,
   output logic [2*W-1:0] prod
);

   localparam int XW = W + 1;
   localparam int PW = 2 * XW;

   // One extra bit per operand turns both interpretations into one signed multiply
   logic signed [XW-1:0] ax;
   logic signed [XW-1:0] bx;
   logic signed [PW-1:0] full;

   assign ax   = {sgn & a[W-1], a};
   assign bx   = {sgn & b[W-1], b};
   assign full = ax * bx;
   assign prod = full[2*W-1:0];

endmodule

// File: rtl/simd_mul_array.sv
module simd_mul_array #(
   parameter int VLEN = 128,
   parameter int W    = 8
) (
   input  logic [VLEN-1:0] a,
   input  logic [VLEN-1:0] b,
   input  logic            sgn,
   output logic [VLEN-1:0] lo,
   output logic [VLEN-1:0] hi
);

   localparam int LANES = VLEN / W;

   if ((VLEN % W) != 0) begin : g_bad_width
      $error("simd_mul_array: VLEN must be a multiple of W");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [2*W-1:0] p;

      simd_mul_lane #(.W(W)) u_lane (
         .a   (a[i*W +: W]),
         .b   (b[i*W +: W]),
         .sgn (sgn),
         .prod(p)
      );

      assign lo[i*W +: W] = p[W-1:0];
      assign hi[i*W +: W] = p[2*W-1:W];
   end

endmodule

// File: rtl/simd_mul_top.sv
module simd_mul_top
   import simd_mul_pkg::*;
#(
   parameter int VLEN    = 128,
   parameter int REG_OUT = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [31:0]          insn,
   input  logic [VLEN-1:0]      src_a,
   input  logic [VLEN-1:0]      src_b,
   output logic [REG_IDX_W-1:0] rd_idx_a,
   output logic [REG_IDX_W-1:0] rd_idx_b,
   output logic                 out_valid,
   output logic                 illegal_op,
   output logic [VLEN-1:0]      result,
   output logic [REG_IDX_W-1:0] dst_idx
);

   if ((VLEN % MAX_LANE_W) != 0 || VLEN < MAX_LANE_W) begin : g_bad_vlen
      $error("simd_mul_top: VLEN must be a positive multiple of the widest lane");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("simd_mul_top: REG_OUT must be 0 or 1");
   end

   mul_op_t              op;
   logic [REG_IDX_W-1:0] dst_dec;
   logic [VLEN-1:0]      lo_all [NUM_SIZES];
   logic [VLEN-1:0]      hi_all [NUM_SIZES];
   logic [VLEN-1:0]      picked;
   logic [VLEN-1:0]      nxt_result;
   logic                 nxt_illegal;

   simd_mul_decode u_dec (
      .insn(insn),
      .op  (op),
      .dst (dst_dec),
      .srca(rd_idx_a),
      .srcb(rd_idx_b)
   );

   // One multiplier array per lane size
   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
      localparam int LW = MIN_LANE_W << g;
      simd_mul_array #(.VLEN(VLEN), .W(LW)) u_arr (
         .a  (src_a),
         .b  (src_b),
         .sgn(op.sgn),
         .lo (lo_all[g]),
         .hi (hi_all[g])
      );
   end

   assign picked      = op.high ? hi_all[op.size] : lo_all[op.size];
   assign nxt_result  = op.legal ? picked : '0;
   assign nxt_illegal = in_valid & ~op.legal;

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            result     <= '0;
            dst_idx    <= '0;
         end else begin
            out_valid  <= in_valid;
            illegal_op <= nxt_illegal;
            if (in_valid) begin
               result  <= nxt_result;
               dst_idx <= dst_dec;
            end
         end
      end
   end else begin : g_comb
      assign out_valid  = in_valid & rst_n;
      assign illegal_op = nxt_illegal & rst_n;
      assign result     = rst_n ? nxt_result : '0;
      assign dst_idx    = rst_n ? dst_dec : '0;
   end

endmodule

// File: rtl/simd_mul_chk.sv
module simd_mul_chk
   import simd_mul_pkg::*;
#(
   parameter int VLEN    = 128,
   parameter int REG_OUT = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [31:0]          insn,
   input logic                 out_valid,
   input logic                 illegal_op,
   input logic [VLEN-1:0]      result,
   input logic [REG_IDX_W-1:0] dst_idx
);

   // R8: a rejected word never produces a nonzero lane
   a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (result == '0));

   // R8: the flag only appears alongside a result
   a_r8_illegal_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> out_valid);

   if (REG_OUT == 1) begin : g_timed
      // R2
      a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R9
      a_r9_dst_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (dst_idx == $past(insn[REG_IDX_W-1:0])));
      // R10
      a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(result) && $stable(dst_idx) && !illegal_op));
   end

endmodule

bind simd_mul_top simd_mul_chk #(.VLEN(VLEN), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .insn      (insn),
   .out_valid (out_valid),
   .illegal_op(illegal_op),
   .result    (result),
   .dst_idx   (dst_idx)
);

// File: tb/sim_simd_mul_top.sv
module sim_simd_mul_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [4:0]   rd_idx_a, rd_idx_b, dst_idx;
   logic         out_valid, illegal_op;
   logic [127:0] result;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_mul_top u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .src_a(src_a), .src_b(src_b), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
      .out_valid(out_valid), .illegal_op(illegal_op), .result(result),
      .dst_idx(dst_idx)
   );

   task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // kind: 0 low, 1 signed high, 2 unsigned high
   function automatic logic [31:0] mk(int kind, int sz, logic [4:0] d, logic [4:0] j, logic [4:0] k);
      logic [2:0] kc;
      kc = (kind == 0) ? 3'b010 : (kind == 1) ? 3'b011 : 3'b100;
      return {4'b0111, 8'b00001000, kc, sz[1:0], k, j, d};
   endfunction

   function automatic logic [127:0] ref_mul(logic [127:0] a, logic [127:0] b, int sz, int kind);
      int w;
      logic [129:0] mask, ua, ub, up;
      logic signed [129:0] xa, xb, p;
      logic [127:0] r;
      w    = 8 << sz;
      mask = (130'd1 << w) - 130'd1;
      r    = '0;
      for (int l = 0; l < 128 / w; l++) begin
         ua = (130'(a) >> (l * w)) & mask;
         ub = (130'(b) >> (l * w)) & mask;
         xa = $signed(ua);
         xb = $signed(ub);
         if (kind == 1 && ua[w-1]) xa = xa - $signed(130'd1 << w);
         if (kind == 1 && ub[w-1]) xb = xb - $signed(130'd1 << w);
         p  = xa * xb;
         up = p;
         if (kind != 0) up = up >> w;
         r  = r | 128'((up & mask) << (l * w));
      end
      return r;
   endfunction

   function automatic logic [127:0] fill(int sz, logic [63:0] v);
      int w;
      logic [127:0] r;
      w = 8 << sz;
      r = '0;
      for (int l = 0; l < 128 / w; l++)
         r = r | (128'(v & ((w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1))) << (l * w));
      return r;
   endfunction

   // Called at a falling edge; returns at the next falling edge after checking
   task automatic run_op(int kind, int sz, logic [127:0] a, logic [127:0] b, string tag);
      logic [4:0] d, j, k;
      logic [127:0] exp;
      string req;
      d = 5'($urandom); j = 5'($urandom); k = 5'($urandom);
      in_valid = 1'b1;
      insn  = mk(kind, sz, d, j, k);
      src_a = a;
      src_b = b;
      #1;
      chk(rd_idx_a == j && rd_idx_b == k, "R9 src idx", {118'd0, rd_idx_a, rd_idx_b}, {118'd0, j, k});
      exp = ref_mul(a, b, sz, kind);
      if (tag != "") req = tag;
      else if (kind != 0 && sz == 3) req = "R6";
      else req = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
      @(negedge clk);
      chk(out_valid === 1'b1 && illegal_op === 1'b0, "R2 valid", {126'd0, out_valid, illegal_op}, 128'd2);
      chk(result === exp, req, result, exp);
      chk(dst_idx === d, "R9 dst", 128'(dst_idx), 128'(d));
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=0", WATCHDOG);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] keep, ra, rb;
      logic [63:0] mn;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1
      chk(out_valid === 1'b0 && illegal_op === 1'b0, "R1 flags", {126'd0, out_valid, illegal_op}, '0);
      chk(result === '0 && dst_idx === '0, "R1 data", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0 && result === '0, "R1 after release", result, '0);

      // Extremes at every lane size and every kind
      for (int sz = 0; sz < 4; sz++) begin
         mn = 64'd1 << ((8 << sz) - 1);
         for (int kind = 0; kind < 3; kind++) begin
            run_op(kind, sz, fill(sz, mn), fill(sz, mn), "");
            run_op(kind, sz, fill(sz, '1), fill(sz, '1), "");
            run_op(kind, sz, fill(sz, mn), fill(sz, '1), "");
         end
      end

      // R6: exact 64-bit products
      run_op(1, 3, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
                   {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, "R6");
      run_op(2, 3, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000},
                   {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000}, "R6");

      // R7: full products in alternating lanes, zeros next to them
      run_op(2, 0, 128'h00FF_00FF_00FF_00FF_00FF_00FF_00FF_00FF,
                   128'h00FF_00FF_00FF_00FF_00FF_00FF_00FF_00FF, "R7");
      run_op(0, 1, 128'h0000_FFFF_0000_FFFF_0000_FFFF_0000_FFFF,
                   128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, "R7");
      run_op(1, 2, 128'h8000_0000_0000_0001_8000_0000_FFFF_FFFF,
                   128'h8000_0000_0000_0001_8000_0000_FFFF_FFFF, "R7");

      // Random operands, back to back
      for (int n = 0; n < 300; n++) begin
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         run_op(int'($urandom % 3), int'($urandom % 4), ra, rb, "");
      end

      // R10: idle cycle keeps the last result
      keep = result;
      in_valid = 1'b0;
      insn  = 32'hFFFF_FFFF;
      src_a = '1;
      src_b = '1;
      @(negedge clk);
      chk(out_valid === 1'b0 && illegal_op === 1'b0, "R10 flags", {126'd0, out_valid, illegal_op}, '0);
      chk(result === keep, "R10 hold", result, keep);

      // R8: undefined minor code
      in_valid = 1'b1;
      insn  = {4'b0111, 8'b00001000, 5'b10100, 15'h1234};
      @(negedge clk);
      chk(illegal_op === 1'b1 && out_valid === 1'b1, "R8 minor flag", {126'd0, out_valid, illegal_op}, 128'd3);
      chk(result === '0, "R8 minor zero", result, '0);

      // R8: wrong major field with an otherwise valid minor
      insn  = {4'b0110, 8'b00001000, 5'b01000, 15'h0421};
      @(negedge clk);
      chk(illegal_op === 1'b1, "R8 major flag", 128'(illegal_op), 128'd1);
      chk(result === '0, "R8 major zero", result, '0);

      // R8: wrong group field
      insn  = {4'b0111, 8'b00001001, 5'b01100, 15'h0000};
      @(negedge clk);
      chk(illegal_op === 1'b1 && result === '0, "R8 group", result, '0);

      // Legal again clears the flag
      run_op(0, 0, fill(0, 64'h03), fill(0, 64'h05), "R3");
      in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule